// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog for a processor subsystem. A prescaler selects one of several clock-enable sources and divides it. The divided ticks drive a 10-bit up counter. Software has to service the watchdog by strobing a counter-clear bit before the counter wraps. If it does not, the wrap raises one of two requests. One is a one-cycle non-maskable interrupt request, which also sets a sticky status flag. The other is a one-cycle system reset request. A control bit picks between them.

The source and division fields are guarded by a 16-bit key register. They accept writes only while the key holds the unlock value 0x0096. Writing any other value to the key locks them again. A 4-bit run code starts and stops counting. A separate bit decides whether counting continues while the debug input is high.

With the default ten counter bits, the timeout lasts 1024 divided ticks from a cleared counter. For example, a 256 Hz tick gives a 4 s timeout. All writes go through a single-cycle write port: `wr_en_i`, a 2-bit address and 16 data bits. The configuration and status values are visible on output ports.

Top module: `wdog_guard`

## Requirements
- R1: After reset the counter is 0, the key is locked, the run code is 4'b1010 (stopped), the status flag and both requests are 0, the source and division fields are 0, and the overflow action is reset.
- R2: Writing 0x0096 to address 0 makes `unlocked_o` 1 from the next cycle. Writing any other value to address 0 makes it 0.
- R3: A write to address 1 updates the source field (bits [1:0]) and the division field (bits [3:2]) only while unlocked. While locked, the write leaves both fields unchanged.
- R4: The counter advances once per 2^d asserted enables of the selected source `src_tick_i[s]`, where d is the division field (0 to 3 gives /1, /2, /4, /8) and s is the source field.
- R5: The counter is a 10-bit up counter. From zero it wraps back to 0 on its 1024th advance.
- R6: When address 2 bit 5 is 1, a wrap pulses `nmi_o` for exactly one cycle and sets `nmi_flag_o`. `rst_req_o` stays 0.
- R7: When address 2 bit 5 is 0, a wrap pulses `rst_req_o` for exactly one cycle and the counter restarts from 0. The flag and `nmi_o` are untouched.
- R8: Writing 1 to address 3 bit 0 clears `nmi_flag_o`, and writing 0 there has no effect. If a wrap sets the flag in the same cycle, the flag ends up set.
- R9: A write to address 2 with bit 6 set clears the counter and the divider phase to 0 on that edge. The bit is not stored.
- R10: Address 2 bits [3:0] hold the run code. The code 4'b1010 holds the counter, and any other code lets it count.
- R11: While `debug_i` is 1, the counter holds unless address 2 bit 4 (debug-run) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 4 | One clock enable per selectable source |
| debug_i | input | 1 | Processor is halted in debug |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 key, 1 clock config, 2 control, 3 status |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 10 | Current counter value |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_flag_o | output | 1 | Sticky interrupt status flag |
| unlocked_o | output | 1 | Key register holds the unlock value |
| clk_src_o | output | 2 | Current source field |
| clk_div_o | output | 2 | Current division field |

## Verification
A write to any register shows up on the output ports one edge after the write cycle. A divided tick moves `count_o` at the same edge it arrives. A wrap is visible one cycle after the edge at which the counter held 1023 and took a tick: `nmi_o` or `rst_req_o` is high, the counter reads 0, and the flag is updated. New source, division, run and action settings govern counting only from the edge after they are written. The bench drives inputs at the falling edge and advances a requirement-level model at each rising edge, then compares every output at the following falling edge. Each comparison therefore lands in the cycle where the registered result is due.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam logic [1:0] ADDR_KEY  = 2'd0;
   localparam logic [1:0] ADDR_CLK  = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;
   localparam logic [1:0] ADDR_STAT = 2'd3;

   localparam logic [15:0] DEF_UNLOCK_KEY = 16'h0096;
   localparam logic [3:0]  DEF_STOP_CODE  = 4'b1010;

   typedef enum logic {
      ACT_RESET = 1'b0,
      ACT_NMI   = 1'b1
   } wdg_action_e;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int KEY_W  = 16,
   parameter int SRC_W  = 2,
   parameter int DIV_W  = 2,
   parameter int RUN_W  = 4,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = KEY_W'(DEF_UNLOCK_KEY),
   parameter logic [RUN_W-1:0] STOP_CODE  = RUN_W'(DEF_STOP_CODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              debug,
   output logic              unlocked,
   output logic [SRC_W-1:0]  src_sel,
   output logic [DIV_W-1:0]  div_sel,
   output logic              run_active,
   output wdg_action_e       action,
   output logic              cnt_clr,
   output logic              flag_clr
);

   localparam int DIV_LSB   = SRC_W;
   localparam int DBG_BIT   = RUN_W;
   localparam int ACT_BIT   = RUN_W + 1;
   localparam int CLR_BIT   = RUN_W + 2;
   localparam int FLAG_BIT  = 0;

   logic [KEY_W-1:0] key_q;
   logic [RUN_W-1:0] run_q;
   logic             dbg_run_q;
   wdg_action_e      act_q;
   logic [SRC_W-1:0] src_q;
   logic [DIV_W-1:0] div_q;

   logic wr_key, wr_clk, wr_ctrl, wr_stat;

   always_comb begin
      wr_key  = wr_en && (wr_addr == ADDR_KEY);
      wr_clk  = wr_en && (wr_addr == ADDR_CLK);
      wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
      wr_stat = wr_en && (wr_addr == ADDR_STAT);
   end

   assign unlocked = (key_q == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (wr_key) begin
         key_q <= wr_data[KEY_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         div_q <= '0;
      end else if (wr_clk && unlocked) begin
         src_q <= wr_data[SRC_W-1:0];
         div_q <= wr_data[DIV_LSB +: DIV_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= STOP_CODE;
         dbg_run_q <= 1'b0;
         act_q     <= ACT_RESET;
      end else if (wr_ctrl) begin
         run_q     <= wr_data[RUN_W-1:0];
         dbg_run_q <= wr_data[DBG_BIT];
         act_q     <= wdg_action_e'(wr_data[ACT_BIT]);
      end
   end

   assign cnt_clr    = wr_ctrl && wr_data[CLR_BIT];
   assign flag_clr   = wr_stat && wr_data[FLAG_BIT];
   assign run_active = (run_q != STOP_CODE) && (!debug || dbg_run_q);
   assign src_sel    = src_q;
   assign div_sel    = div_q;
   assign action     = act_q;

   AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> ($stable(src_sel) && $stable(div_sel))); // R3

   AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && (wr_data[KEY_W-1:0] == UNLOCK_KEY)) |=> unlocked); // R2

   AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && (wr_data[KEY_W-1:0] != UNLOCK_KEY)) |=> !unlocked); // R2

   AST_DEBUG_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (debug && !dbg_run_q) |-> !run_active); // R11

endmodule

// File: rtl/wdg_clkdiv.sv
module wdg_clkdiv #(
   parameter int NSRC  = 4,
   parameter int SRC_W = 2,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SRC_W-1:0] src_sel,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             phase_clr,
   output logic             cnt_tick
);

   localparam int PH_W = (1 << DIV_W) - 1;

   logic            sel_tick;
   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] mask;

   generate
      if (NSRC == 1) begin : g_single_src
         assign sel_tick = src_tick[0];
      end else begin : g_multi_src
         always_comb begin
            sel_tick = 1'b0;
            for (int i = 0; i < NSRC; i++) begin
               if (src_sel == SRC_W'(i)) sel_tick = src_tick[i];
            end
         end
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < PH_W; i++) begin
         mask[i] = (i < int'(div_sel));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (phase_clr) begin
         phase_q <= '0;
      end else if (sel_tick) begin
         phase_q <= phase_q + PH_W'(1);
      end
   end

   assign cnt_tick = sel_tick && ((phase_q & mask) == mask);

   AST_TICK_FROM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_tick |-> (src_tick != '0)); // R4

   AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> (phase_q == '0)); // R9

endmodule

// File: rtl/wdg_count.sv
module wdg_count
   import wdg_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_active,
   input  logic             clr,
   input  wdg_action_e      action,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             nmi_pulse,
   output logic             rst_pulse,
   output logic             nmi_flag
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             advance;
   logic             wrap;

   assign advance = tick && run_active && !clr;
   assign wrap    = advance && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (advance) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_pulse <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         nmi_pulse <= wrap && (action == ACT_NMI);
         rst_pulse <= wrap && (action == ACT_RESET);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_flag <= 1'b0;
      end else if (wrap && (action == ACT_NMI)) begin
         nmi_flag <= 1'b1;
      end else if (flag_clr) begin
         nmi_flag <= 1'b0;
      end
   end

   assign count = cnt_q;

   AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ((count == $past(count) + CNT_W'(1)) || (count == '0))); // R5

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_active && !clr) |=> $stable(count)); // R10

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R9

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |=> !nmi_pulse); // R6

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse); // R7

   AST_RST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (count == '0)); // R7

   AST_NMI_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |-> nmi_flag); // R6

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
   import wdg_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int SRC_W  = 2,
   parameter int DIV_W  = 2,
   parameter int CNT_W  = 10,
   parameter int DATA_W = 16,
   parameter int KEY_W  = 16,
   parameter int RUN_W  = 4,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = KEY_W'(DEF_UNLOCK_KEY),
   parameter logic [RUN_W-1:0] STOP_CODE  = RUN_W'(DEF_STOP_CODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_tick_i,
   input  logic              debug_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              nmi_o,
   output logic              rst_req_o,
   output logic              nmi_flag_o,
   output logic              unlocked_o,
   output logic [SRC_W-1:0]  clk_src_o,
   output logic [DIV_W-1:0]  clk_div_o
);

   generate
      if (CNT_W < 2) begin : g_chk_cnt
         $error("wdog_guard: CNT_W must be at least 2");
      end
      if (NSRC < 1 || NSRC > (1 << SRC_W)) begin : g_chk_src
         $error("wdog_guard: NSRC must fit the source field");
      end
      if (DIV_W < 1 || DIV_W > 3) begin : g_chk_div
         $error("wdog_guard: DIV_W must be 1 to 3");
      end
      if (DATA_W < KEY_W || DATA_W < RUN_W + 3 || DATA_W < SRC_W + DIV_W) begin : g_chk_data
         $error("wdog_guard: DATA_W too narrow for the register fields");
      end
   endgenerate

   logic        run_active;
   logic        cnt_clr;
   logic        flag_clr;
   logic        cnt_tick;
   wdg_action_e action;

   wdg_regs #(
      .DATA_W     (DATA_W),
      .KEY_W      (KEY_W),
      .SRC_W      (SRC_W),
      .DIV_W      (DIV_W),
      .RUN_W      (RUN_W),
      .UNLOCK_KEY (UNLOCK_KEY),
      .STOP_CODE  (STOP_CODE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en_i),
      .wr_addr    (wr_addr_i),
      .wr_data    (wr_data_i),
      .debug      (debug_i),
      .unlocked   (unlocked_o),
      .src_sel    (clk_src_o),
      .div_sel    (clk_div_o),
      .run_active (run_active),
      .action     (action),
      .cnt_clr    (cnt_clr),
      .flag_clr   (flag_clr)
   );

   wdg_clkdiv #(
      .NSRC  (NSRC),
      .SRC_W (SRC_W),
      .DIV_W (DIV_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_tick  (src_tick_i),
      .src_sel   (clk_src_o),
      .div_sel   (clk_div_o),
      .phase_clr (cnt_clr),
      .cnt_tick  (cnt_tick)
   );

   wdg_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (cnt_tick),
      .run_active (run_active),
      .clr        (cnt_clr),
      .action     (action),
      .flag_clr   (flag_clr),
      .count      (count_o),
      .nmi_pulse  (nmi_o),
      .rst_pulse  (rst_req_o),
      .nmi_flag   (nmi_flag_o)
   );

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_o && rst_req_o)); // R6 R7

   AST_RST_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_o && !($past(wr_en_i) && ($past(wr_addr_i) == ADDR_STAT))) |-> $stable(nmi_flag_o)); // R7

endmodule

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        debug = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;

   logic [9:0]  count_o;
   logic        nmi_o, rst_req_o, nmi_flag_o, unlocked_o;
   logic [1:0]  clk_src_o, clk_div_o;

   int checks = 0;
   int errors = 0;

   wdog_guard dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_tick_i (src_tick),
      .debug_i    (debug),
      .wr_en_i    (wr_en),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .count_o    (count_o),
      .nmi_o      (nmi_o),
      .rst_req_o  (rst_req_o),
      .nmi_flag_o (nmi_flag_o),
      .unlocked_o (unlocked_o),
      .clk_src_o  (clk_src_o),
      .clk_div_o  (clk_div_o)
   );

   always #5 clk = ~clk;

   // reference state built from the requirements
   logic [15:0] m_key;
   logic [1:0]  m_src, m_div;
   logic [3:0]  m_run;
   logic        m_dbg, m_sel;
   logic [2:0]  m_phase;
   logic [9:0]  m_cnt;
   logic        m_flag, m_nmi, m_rst;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_update();
      logic clr, fclr, st, tk, act, ovf;
      logic [2:0] mask;
      if (!rst_n) begin
         m_key = '0; m_src = '0; m_div = '0; m_run = 4'b1010; m_dbg = 0; m_sel = 0;
         m_phase = '0; m_cnt = '0; m_flag = 0; m_nmi = 0; m_rst = 0;
         return;
      end
      clr  = wr_en && wr_addr == 2'd2 && wr_data[6];
      fclr = wr_en && wr_addr == 2'd3 && wr_data[0];
      st   = src_tick[m_src];
      mask = 3'((1 << m_div) - 1);
      tk   = st && ((m_phase & mask) == mask);
      act  = (m_run != 4'b1010) && (!debug || m_dbg);
      ovf  = tk && act && !clr && (m_cnt == 10'h3FF);
      m_nmi = ovf && m_sel;
      m_rst = ovf && !m_sel;
      if (ovf && m_sel) m_flag = 1'b1;
      else if (fclr) m_flag = 1'b0;
      if (clr) m_cnt = '0;
      else if (tk && act) m_cnt = m_cnt + 10'd1;
      if (clr) m_phase = '0;
      else if (st) m_phase = m_phase + 3'd1;
      if (wr_en) begin
         case (wr_addr)
            2'd0: m_key = wr_data;
            2'd1: if (m_key == 16'h0096) begin m_src = wr_data[1:0]; m_div = wr_data[3:2]; end
            2'd2: begin m_run = wr_data[3:0]; m_dbg = wr_data[4]; m_sel = wr_data[5]; end
            default: ;
         endcase
      end
   endtask

   task automatic compare_all();
      chk("R5", "count", count_o, m_cnt);
      chk("R6", "nmi", nmi_o, m_nmi);
      chk("R7", "rst_req", rst_req_o, m_rst);
      chk("R8", "flag", nmi_flag_o, m_flag);
      chk("R2", "unlocked", unlocked_o, int'(m_key == 16'h0096));
      chk("R3", "src", clk_src_o, m_src);
      chk("R3", "div", clk_div_o, m_div);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset values
      chk("R1", "count", count_o, 0);
      chk("R1", "flag", nmi_flag_o, 0);
      chk("R1", "requests", {nmi_o, rst_req_o}, 0);
      chk("R1", "unlocked", unlocked_o, 0);
      chk("R1", "src/div", {clk_src_o, clk_div_o}, 0);
      src_tick = 4'hF;
      repeat (5) cyc();
      chk("R1", "stopped count", count_o, 0);

      // R3 locked write ignored
      wr(2'd1, 16'h000D);
      chk("R3", "locked src", clk_src_o, 0);
      chk("R3", "locked div", clk_div_o, 0);
      // R2 unlock
      wr(2'd0, 16'h0096);
      chk("R2", "unlock", unlocked_o, 1);
      wr(2'd1, 16'h0000);

      // R6 NMI overflow, /1
      wr(2'd2, 16'h0060);  // run, action nmi, clear
      for (int i = 0; i < 1100 && count_o != 10'h3FF; i++) cyc();
      chk("R5", "count at max", count_o, 1023);
      cyc();
      chk("R6", "nmi pulse", nmi_o, 1);
      chk("R5", "wrapped", count_o, 0);
      chk("R6", "flag set", nmi_flag_o, 1);
      cyc();
      chk("R6", "nmi single", nmi_o, 0);
      // R8 write 0 no effect, write 1 clears
      wr(2'd3, 16'h0000);
      chk("R8", "flag kept", nmi_flag_o, 1);
      wr(2'd3, 16'h0001);
      chk("R8", "flag cleared", nmi_flag_o, 0);

      // R7 reset action
      wr(2'd2, 16'h0040);
      for (int i = 0; i < 1100 && count_o != 10'h3FF; i++) cyc();
      cyc();
      chk("R7", "rst pulse", rst_req_o, 1);
      chk("R7", "restart", count_o, 0);
      chk("R7", "no nmi", nmi_o, 0);
      cyc();
      chk("R7", "rst single", rst_req_o, 0);

      // R10 stop code holds
      repeat (7) cyc();
      wr(2'd2, 16'h000A);
      begin
         logic [9:0] held;
         held = count_o;
         repeat (10) cyc();
         chk("R10", "stopped", count_o, held);
      end
      // R11 debug halt and debug run
      wr(2'd2, 16'h0040);
      debug = 1'b1;
      cyc();
      chk("R11", "debug halts", count_o, 0);
      wr(2'd2, 16'h0010);
      cyc(); cyc();
      chk("R11", "debug run", count_o, 2);
      debug = 1'b0;

      // R4 divide by 8 on source 2
      wr(2'd1, 16'h000E);
      src_tick = 4'b0100;
      wr(2'd2, 16'h0040);
      repeat (16) cyc();
      chk("R4", "div8 of 16", count_o, 2);
      src_tick = 4'b1011;
      repeat (8) cyc();
      chk("R4", "other sources", count_o, 2);
      // R9 clear strobe
      src_tick = 4'b0100;
      repeat (5) cyc();
      wr(2'd2, 16'h0040);
      chk("R9", "clear", count_o, 0);

      // R2/R3 relock
      wr(2'd0, 16'h1234);
      chk("R2", "relock", unlocked_o, 0);
      wr(2'd1, 16'h0001);
      chk("R3", "relocked src", clk_src_o, 2);

      // random phase
      wr(2'd0, 16'h0096);
      wr(2'd1, 16'h0000);
      for (int n = 0; n < 20000; n++) begin
         src_tick = 4'($urandom) | (($urandom % 4) != 0 ? 4'h1 : 4'h0);
         debug = ($urandom % 16) == 0;
         if (($urandom % 40) == 0) begin
            wr_en = 1'b1;
            wr_addr = 2'($urandom);
            case (wr_addr)
               2'd0: wr_data = (($urandom % 2) != 0) ? 16'h0096 : 16'($urandom);
               2'd1: wr_data = 16'($urandom % 6);
               2'd2: wr_data = {9'd0, (($urandom % 4) == 0), 2'($urandom), (($urandom % 3) == 0) ? 4'b1010 : 4'($urandom)};
               default: wr_data = 16'($urandom);
            endcase
         end else begin
            wr_en = 1'b0;
         end
         cyc();
      end
      wr_en = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule